// File: doc/BRIEF.md
# Indirect Lookup Table Access Port

This block lets a host reach six internal lookup tables through only two 16-bit registers. A select register names one table and a starting slot, and a data register reads or writes that slot. The tables are curve tables for a colour grading stage: hue against hue, hue against saturation, lightness against saturation, saturation against saturation, lightness against lightness, and hue against lightness. Each table has 64 slots. The hue-against-hue table holds signed 14-bit entries and the other five hold unsigned 12-bit entries.

In normal mode every data-register access goes to the same slot. In bulk mode the slot index advances by one after each data access, so a whole table can be loaded or dumped with back-to-back accesses after one select write. Written data is cut to the width of the selected table. Read data is sign-extended or zero-extended to 16 bits to suit the table. A separate read port lets the pixel pipeline fetch any entry of any table with one cycle of latency, and it does not disturb the host.

The host bus is a simple register bus with write-enable, read-enable, address, write data, read data and a read-valid strobe. The asynchronous reset is released synchronously inside the block.

Top module: `lut_window_port`

## Requirements
- R1: The select register is at address SEL_ADDR (default 0). Its bit 0 is the access mode (0 normal, 1 bulk), bits 6:1 are the slot index and bits 9:7 are the table code. Bits 15:10 are reserved: they are not stored and read back as zero. A host read of SEL_ADDR returns the current select value.
- R2: Table codes 0 to 5 select six independent tables. Code 0 (hue-vs-hue) holds signed 14-bit entries. Codes 1 (hue-vs-saturation), 2 (lightness-vs-saturation), 3 (saturation-vs-saturation), 4 (lightness-vs-lightness) and 5 (hue-vs-lightness) hold unsigned 12-bit entries. A write to one table leaves the others unchanged.
- R3: In normal mode, reads and writes of the data register at DATA_ADDR (default 1) all go to the slot that the select register names, and the select register does not change.
- R4: In bulk mode, each accepted read or write of the data register raises the index by one after the access. The index wraps from 63 to 0, and the table code and mode do not change.
- R5: A data write stores the low bits of the write data that fit the selected table (14 for code 0, 12 otherwise). A data read returns the entry sign-extended from bit 13 for code 0, and zero-extended from bit 11 for codes 1 to 5.
- R6: Table codes 6 and 7 are reserved. Data writes to them change no table, data reads from them return zero, and in bulk mode the index still advances on each such access.
- R7: A read is accepted when host_rd_en is high and host_wr_en is low. host_rvalid is high, with host_rdata, exactly in the next cycle. When both enables are high, only the write takes place: no read is returned and the index advances at most once. Addresses other than SEL_ADDR and DATA_ADDR read as zero, and writes to them change nothing.
- R8: pipe_data returns the entry at pipe_tbl/pipe_idx one cycle after they are presented, extended as in R5. It returns zero for codes 6 and 7, and host traffic has no effect on it.
- R9: After reset the select register is zero (table 0, index 0, normal mode) and host_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | ADDR_W (4) | Host register address |
| host_wdata | input | DATA_W (16) | Host write data |
| host_rdata | output | DATA_W (16) | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | High one cycle after an accepted read |
| pipe_tbl | input | TSEL_W (3) | Pipeline read table code |
| pipe_idx | input | IDX_W (6) | Pipeline read slot index |
| pipe_data | output | DATA_W (16) | Pipeline read data, one cycle after the request |

## Verification
The bench builds the block with its default parameters. With IDX_W at 6, a bulk run that starts at slot 60 crosses the wrap to slot 0 within eight accesses. With TSEL_W at 3 and NUM_TBL at 6, codes 6 and 7 are left as reserved tables that the host and pipeline ports can both address. With the two registers at addresses 0 and 1 of a 4-bit space, unmapped addresses are also reachable. With these settings the bench can check sign extension on table 0, truncation on the 12-bit tables, collisions of simultaneous strobes, and whether a write to one table leaks into another.

// File: rtl/lut_port_pkg.sv
package lut_port_pkg;

  // Source of the value returned on the host read data bus.
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_SEL  = 2'd1,
    SRC_DATA = 2'd2
  } rd_src_e;

endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/lut_sel_reg.sv
module lut_sel_reg #(
  parameter int TSEL_W = 3,
  parameter int IDX_W  = 6,
  localparam int SEL_W = TSEL_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wdata,
  input  logic              data_acc,
  output logic [TSEL_W-1:0] tbl,
  output logic [IDX_W-1:0]  idx,
  output logic              bulk
);

  logic [TSEL_W-1:0] tbl_q, tbl_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              bulk_q, bulk_d;
  logic              en;

  // Next state: a select write has priority over the bulk step.
  always_comb begin
    tbl_d  = tbl_q;
    idx_d  = idx_q;
    bulk_d = bulk_q;
    en     = 1'b0;
    if (sel_wr) begin
      en = 1'b1;
      {tbl_d, idx_d, bulk_d} = sel_wdata;
    end else if (data_acc && bulk_q) begin
      en    = 1'b1;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      idx_q  <= '0;
      bulk_q <= 1'b0;
    end else if (en) begin
      tbl_q  <= tbl_d;
      idx_q  <= idx_d;
      bulk_q <= bulk_d;
    end
  end

  assign tbl  = tbl_q;
  assign idx  = idx_q;
  assign bulk = bulk_q;

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int WIDTH  = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  parameter bit SIGNED = 1'b0,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              host_rd,
  input  logic [IDX_W-1:0]  pipe_idx,
  output logic [DATA_W-1:0] host_ext,
  output logic [DATA_W-1:0] pipe_ext
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] host_q;
  logic [WIDTH-1:0] pipe_q;

  // Storage array with one write port and two registered read ports.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[host_idx] <= wr_data;
    end
    if (host_rd) begin
      host_q <= mem[host_idx];
    end
    pipe_q <= mem[pipe_idx];
  end

  generate
    if (SIGNED) begin : g_sext
      assign host_ext = {{(DATA_W-WIDTH){host_q[WIDTH-1]}}, host_q};
      assign pipe_ext = {{(DATA_W-WIDTH){pipe_q[WIDTH-1]}}, pipe_q};
    end else begin : g_zext
      assign host_ext = {{(DATA_W-WIDTH){1'b0}}, host_q};
      assign pipe_ext = {{(DATA_W-WIDTH){1'b0}}, pipe_q};
    end
  endgenerate

endmodule

// File: rtl/lut_window_port.sv
module lut_window_port
  import lut_port_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int SEL_ADDR  = 0,
  parameter int DATA_ADDR = 1,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 6,
  parameter int TSEL_W    = 3,
  parameter int NUM_TBL   = 6,
  parameter int HH_W      = 14,
  parameter int SAT_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic [TSEL_W-1:0] pipe_tbl,
  input  logic [IDX_W-1:0]  pipe_idx,
  output logic [DATA_W-1:0] pipe_data
);

  localparam int SEL_W = TSEL_W + IDX_W + 1;
  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_ADDR);

  logic rst_sync_n;

  lut_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // Access decode: a write wins over a read in the same cycle.
  logic rd_act, sel_wr, data_wr, data_rd;
  assign rd_act  = host_rd_en && !host_wr_en;
  assign sel_wr  = host_wr_en && (host_addr == SEL_A);
  assign data_wr = host_wr_en && (host_addr == DAT_A);
  assign data_rd = rd_act && (host_addr == DAT_A);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^host_wdata[DATA_W-1:SEL_W];

  logic [TSEL_W-1:0] cur_tbl;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_bulk;

  lut_sel_reg #(.TSEL_W(TSEL_W), .IDX_W(IDX_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_wr    (sel_wr),
    .sel_wdata (host_wdata[SEL_W-1:0]),
    .data_acc  (data_wr || data_rd),
    .tbl       (cur_tbl),
    .idx       (cur_idx),
    .bulk      (cur_bulk)
  );

  logic [DATA_W-1:0] host_ext [NUM_TBL];
  logic [DATA_W-1:0] pipe_ext [NUM_TBL];

  generate
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_bank
      localparam int W  = (t == 0) ? HH_W : SAT_W;
      localparam bit SX = (t == 0);
      lut_bank #(.WIDTH(W), .IDX_W(IDX_W), .DATA_W(DATA_W), .SIGNED(SX)) u_bank (
        .clk      (clk),
        .wr_en    (data_wr && (cur_tbl == TSEL_W'(t))),
        .host_idx (cur_idx),
        .wr_data  (host_wdata[W-1:0]),
        .host_rd  (data_rd),
        .pipe_idx (pipe_idx),
        .host_ext (host_ext[t]),
        .pipe_ext (pipe_ext[t])
      );
    end
  endgenerate

  // Read-side tracking registers.
  rd_src_e           rd_src_q, rd_src_d;
  logic [TSEL_W-1:0] rd_tbl_q, rd_tbl_d;
  logic              rvalid_q, rvalid_d;
  logic [TSEL_W-1:0] pipe_tbl_q;

  always_comb begin
    rvalid_d = rd_act;
    rd_src_d = SRC_ZERO;
    rd_tbl_d = rd_tbl_q;
    if (rd_act) begin
      rd_tbl_d = cur_tbl;
      if (host_addr == SEL_A) begin
        rd_src_d = SRC_SEL;
      end else if (host_addr == DAT_A) begin
        rd_src_d = SRC_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_src_q   <= SRC_ZERO;
      rd_tbl_q   <= '0;
      rvalid_q   <= 1'b0;
      pipe_tbl_q <= '0;
    end else begin
      rd_src_q   <= rd_src_d;
      rd_tbl_q   <= rd_tbl_d;
      rvalid_q   <= rvalid_d;
      pipe_tbl_q <= pipe_tbl;
    end
  end

  // Output selection; reserved codes fall through to zero.
  logic [DATA_W-1:0] host_mux, pipe_mux;

  always_comb begin
    host_mux = '0;
    pipe_mux = '0;
    for (int t = 0; t < NUM_TBL; t++) begin
      if (rd_tbl_q == TSEL_W'(t)) host_mux = host_ext[t];
      if (pipe_tbl_q == TSEL_W'(t)) pipe_mux = pipe_ext[t];
    end
  end

  always_comb begin
    case (rd_src_q)
      SRC_SEL:  host_rdata = {{(DATA_W-SEL_W){1'b0}}, cur_tbl, cur_idx, cur_bulk};
      SRC_DATA: host_rdata = host_mux;
      default:  host_rdata = '0;
    endcase
  end

  assign host_rvalid = rvalid_q;
  assign pipe_data   = pipe_mux;

endmodule

// File: rtl/lut_window_port_chk.sv
module lut_window_port_chk #(
  parameter int ADDR_W    = 4,
  parameter int SEL_ADDR  = 0,
  parameter int DATA_ADDR = 1,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 6,
  parameter int TSEL_W    = 3,
  parameter int NUM_TBL   = 6,
  parameter int HH_W      = 14,
  parameter int SAT_W     = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic              host_rd_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic [TSEL_W-1:0] cur_tbl,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              cur_bulk,
  input logic [TSEL_W-1:0] pipe_tbl,
  input logic [DATA_W-1:0] pipe_data
);

  logic rd_ok, dat_hit, sel_hit;
  assign rd_ok   = host_rd_en && !host_wr_en;
  assign dat_hit = (host_addr == ADDR_W'(DATA_ADDR));
  assign sel_hit = (host_addr == ADDR_W'(SEL_ADDR));

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> host_rvalid); // R7

  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> !host_rvalid); // R7

  AST_NORMAL_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_bulk && !(host_wr_en && sel_hit)) |=> $stable({cur_tbl, cur_idx, cur_bulk})); // R3

  AST_BULK_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bulk && dat_hit && (host_wr_en || host_rd_en))
      |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && $stable(cur_tbl) && cur_bulk); // R4

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && dat_hit && (cur_tbl >= TSEL_W'(NUM_TBL))) |=> (host_rdata == '0)); // R6

  AST_UNSIGNED_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && dat_hit && (cur_tbl != '0) && (cur_tbl < TSEL_W'(NUM_TBL)))
      |=> (host_rdata[DATA_W-1:SAT_W] == '0)); // R5

  AST_SIGNED_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && dat_hit && (cur_tbl == '0))
      |=> (($countones(host_rdata[DATA_W-1:HH_W-1]) == 0) ||
           ($countones(host_rdata[DATA_W-1:HH_W-1]) == DATA_W-HH_W+1))); // R5

  AST_PIPE_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_tbl >= TSEL_W'(NUM_TBL)) |=> (pipe_data == '0)); // R8

endmodule

bind lut_window_port lut_window_port_chk #(
  .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR), .DATA_W(DATA_W),
  .IDX_W(IDX_W), .TSEL_W(TSEL_W), .NUM_TBL(NUM_TBL), .HH_W(HH_W), .SAT_W(SAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .host_wr_en  (host_wr_en),
  .host_rd_en  (host_rd_en),
  .host_addr   (host_addr),
  .host_rdata  (host_rdata),
  .host_rvalid (host_rvalid),
  .cur_tbl     (cur_tbl),
  .cur_idx     (cur_idx),
  .cur_bulk    (cur_bulk),
  .pipe_tbl    (pipe_tbl),
  .pipe_data   (pipe_data)
);

// File: tb/lut_window_port_tb.sv
`timescale 1ns/1ps
module lut_window_port_tb_top;

  localparam logic [3:0] A_SEL = 4'd0;
  localparam logic [3:0] A_DAT = 4'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic [2:0]  pipe_tbl = '0;
  logic [5:0]  pipe_idx = '0;
  logic [15:0] pipe_data;

  always #4 clk = ~clk;

  lut_window_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .pipe_tbl(pipe_tbl), .pipe_idx(pipe_idx), .pipe_data(pipe_data)
  );

  int checks = 0;
  int errors = 0;

  // Bench model of the select register and the tables.
  logic [2:0]  m_tbl = '0;
  logic [5:0]  m_idx = '0;
  logic        m_bulk = 1'b0;
  logic [15:0] m_mem [8][64];

  logic [15:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [15:0] ext_val(input logic [2:0] t, input logic [15:0] d);
    if (t == 3'd0) return {{2{d[13]}}, d[13:0]};
    else if (t < 3'd6) return {4'h0, d[11:0]};
    else return 16'h0;
  endfunction

  function automatic logic [15:0] sel_word(input logic [2:0] t, input logic [5:0] i, input logic b);
    return {6'b0, t, i, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver tasks: called at a negative edge, return at the next one.
  task automatic host_wr(input logic [3:0] a, input logic [15:0] d);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    if (a == A_SEL) begin
      {m_tbl, m_idx, m_bulk} = d[9:0];
    end else if (a == A_DAT) begin
      if (m_tbl < 3'd6) m_mem[m_tbl][m_idx] = ext_val(m_tbl, d);
      if (m_bulk) m_idx = m_idx + 1'b1;
    end
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, input string tag);
    logic [15:0] e;
    e = 16'h0;
    if (a == A_SEL) begin
      e = sel_word(m_tbl, m_idx, m_bulk);
    end else if (a == A_DAT) begin
      e = (m_tbl < 3'd6) ? m_mem[m_tbl][m_idx] : 16'h0;
      if (m_bulk) m_idx = m_idx + 1'b1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  task automatic set_sel(input logic [2:0] t, input logic [5:0] i, input logic b);
    host_wr(A_SEL, sel_word(t, i, b));
  endtask

  task automatic pipe_chk(input logic [2:0] t, input logic [5:0] i, input logic [15:0] e, input string tag);
    pipe_tbl = t; pipe_idx = i;
    @(negedge clk);
    chk(pipe_data === e, tag, pipe_data, e);
  endtask

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected rvalid", host_rdata, 16'h0);
      end else begin
        logic [15:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(host_rdata === e, tg, host_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(host_rvalid === 1'b0, "R9 rvalid in reset", {15'b0, host_rvalid}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: select register comes out of reset at zero.
    host_rd(A_SEL, "R9 select after reset");

    // R1: field layout and reserved upper bits.
    set_sel(3'd0, 6'd5, 1'b0);
    host_rd(A_SEL, "R1 select readback");
    host_wr(A_SEL, 16'hFC00 | sel_word(3'd0, 6'd5, 1'b0));
    host_rd(A_SEL, "R1 reserved bits read zero");

    // R3, R5: normal mode repeated access, signed table.
    host_wr(A_DAT, 16'h2001);
    host_rd(A_DAT, "R5 sign extend table 0");
    host_rd(A_DAT, "R3 normal mode same slot");
    host_rd(A_SEL, "R3 index unchanged");

    // R2, R5: unsigned table truncation and independence.
    set_sel(3'd1, 6'd5, 1'b0);
    host_wr(A_DAT, 16'hFABC);
    host_rd(A_DAT, "R5 truncate table 1");
    set_sel(3'd0, 6'd5, 1'b0);
    host_rd(A_DAT, "R2 table 0 untouched by table 1");
    set_sel(3'd5, 6'd7, 1'b0);
    host_wr(A_DAT, 16'h8FFF);
    host_rd(A_DAT, "R5 zero extend table 5");

    // R4: bulk writes across the wrap.
    set_sel(3'd3, 6'd60, 1'b1);
    for (int k = 0; k < 8; k++) host_wr(A_DAT, 16'h0100 + 16'(k));
    host_rd(A_SEL, "R4 index wrapped, table kept");
    set_sel(3'd3, 6'd60, 1'b1);
    for (int k = 0; k < 8; k++) host_rd(A_DAT, "R4 bulk read sequence");
    host_rd(A_SEL, "R4 index after bulk reads");

    // R6: reserved table codes.
    set_sel(3'd6, 6'd0, 1'b1);
    host_wr(A_DAT, 16'h1234);
    host_rd(A_SEL, "R6 index advances on reserved write");
    host_rd(A_DAT, "R6 reserved read zero");
    set_sel(3'd7, 6'd5, 1'b0);
    host_wr(A_DAT, 16'h0555);
    host_rd(A_DAT, "R6 reserved code 7 read zero");

    // R7: simultaneous strobes, write wins.
    set_sel(3'd4, 6'd9, 1'b1);
    host_rd_en = 1'b1;
    host_wr(A_DAT, 16'h0777);
    host_rd_en = 1'b0;
    chk(host_rvalid === 1'b0, "R7 read dropped on collision", {15'b0, host_rvalid}, 16'h0);
    host_rd(A_SEL, "R7 single index step on collision");
    set_sel(3'd4, 6'd9, 1'b0);
    host_rd(A_DAT, "R7 collision write stored");

    // R7: unmapped address.
    host_wr(4'd5, 16'hFFFF);
    host_rd(4'd5, "R7 unmapped read zero");
    host_rd(A_SEL, "R7 unmapped write ignored");

    // R8: pipeline read port, including reserved-code isolation (R6).
    pipe_chk(3'd0, 6'd5, 16'hE001, "R8 pipe table 0");
    pipe_chk(3'd1, 6'd5, 16'h0ABC, "R8 pipe table 1 after reserved writes");
    pipe_chk(3'd3, 6'd61, 16'h0101, "R8 pipe table 3");
    pipe_chk(3'd7, 6'd5, 16'h0000, "R8 pipe reserved zero");
    host_rd_en = 1'b1; host_addr = A_DAT;
    exp_q.push_back(m_mem[4][9]); tag_q.push_back("R8 host read beside pipe");
    pipe_chk(3'd5, 6'd7, 16'h0FFF, "R8 pipe unaffected by host read");
    host_rd_en = 1'b0;

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule